// File: doc/BRIEF.md
# Asynchronous Strobe-Handshake Bus Master

This block sequences bus cycles on an asynchronous bus with a 16-bit data path and a parameterised byte address (24 bits by default). An internal requester hands it one request at a time: a read, a write, or an interrupt acknowledge. Each request carries a byte address, a byte/word size, write data and an interrupt level. The block presents the address and transfer direction first. It then asserts the address strobe and the byte-lane strobes, and holds them for as many clocks as it takes until the external acknowledge arrives. It then negates the strobes and waits for the acknowledge to go away before it starts anything new. Read data and a one-clock response pulse go back to the requester.

A static width input, captured while reset is high, picks between a 16-bit data path and an 8-bit path. On the 8-bit path every transfer uses the low byte lane only, and a word request is split into two byte cycles. A bus-request/bus-grant pair lets an external master take the bus. Grant is given only between cycles. While the bus is granted away, every bus output enable is low and new requests wait.

Top module: `strobe_bus_master`

## Requirements
- R1: Holding `rst` high for at least one clock leaves the bus owned and idle: `bus_as_n`, `bus_uds_n`, `bus_lds_n`, `bus_bg_n` high; `bus_dout_oe`, `rsp_valid` low; `bus_addr_oe`, `bus_ctl_oe`, `req_ready` high.
- R2: Address and `bus_rw` take their cycle values at least one clock before `bus_as_n` falls and stay unchanged while it is low. For writes, `bus_dout_oe` is already high when the strobes assert.
- R3: `bus_rw` is 1 for read and interrupt-acknowledge cycles and 0 for write cycles. `req_kind` encodes 0 = read, 1 = write, 2 = interrupt acknowledge. `req_word` is 1 for a 16-bit transfer and 0 for a byte.
- R4: In 16-bit mode, a word request runs one cycle at the even address (bit 0 cleared) with both strobes low, and the data is carried on `bus_din`/`bus_dout` as is. A byte request at an even address uses `bus_uds_n` and lane 15..8. At an odd address it uses `bus_lds_n` and lane 7..0. Write bytes appear on both lanes, and read bytes return in `rsp_rdata[7:0]` with the upper byte zero.
- R5: In 8-bit mode, only `bus_lds_n` and lane 7..0 are used, and `bus_uds_n` stays high. A word request runs two cycles: first at the even address, carrying the upper byte (`rsp_rdata[15:8]` / `req_wdata[15:8]`), then at the odd address carrying the lower byte.
- R6: An interrupt-acknowledge cycle drives address bits 3..1 with `req_level` and every other address bit with 1. It is a read with only `bus_lds_n` asserted, and it returns `{8'h00, lane 7..0}`.
- R7: Strobes stay asserted, adding wait states without limit, until `bus_dtack_n` is seen low. They are then negated, and read data taken from `bus_din` while acknowledge was low is returned.
- R8: A new address strobe never asserts while `bus_dtack_n` from the previous cycle is still low.
- R9: `mode_wide` (1 = 16-bit, 0 = 8-bit) is used only as captured during reset. Changing it afterwards has no effect.
- R10: With `bus_br_n` low, `bus_bg_n` goes low only once no cycle is in progress. While granted, strobes are negated, all output enables are low and `req_ready` is low. Raising `bus_br_n` ends the grant, and a held request then runs.
- R11: Every accepted request produces exactly one single-clock `rsp_valid` pulse, after its last cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `mode_wide` |
| mode_wide | input | 1 | Data path width select, 1 = 16-bit, 0 = 8-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_kind | input | 2 | 0 read, 1 write, 2 interrupt acknowledge |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7..0) |
| req_level | input | 3 | Interrupt level being acknowledged |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_valid` |
| bus_addr | output | ADDR_W | Bus address |
| bus_addr_oe | output | 1 | Output enable for `bus_addr` |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper lane (15..8) strobe, active low |
| bus_lds_n | output | 1 | Lower lane (7..0) strobe, active low |
| bus_ctl_oe | output | 1 | Output enable for strobes and `bus_rw` |
| bus_dout | output | 16 | Write data to the bus |
| bus_dout_oe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 16 | Read data from the bus |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low |
| bus_br_n | input | 1 | External bus request, active low |
| bus_bg_n | output | 1 | Bus grant, active low |

## Verification
The bench builds the block with `ADDR_W = 8` and `SYNC_STAGES = 2`. The narrow address lets every byte address, even and odd, take word and byte reads and writes in both data-path modes. The bench also covers all eight interrupt levels, with acknowledge delays of zero to three clocks and acknowledge tails of zero to two clocks. A bus-side byte memory is written only through the strobes, and every read is compared against a shadow copy that the bench updates arithmetically. This exposes lane, order and byte-split faults. Separate scenarios change the width input after reset and raise a bus request mid-cycle and during a waiting request.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_IACK  = 2'd2
  } xfer_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETUP,
    S_STROBE,
    S_RECOVER
  } seq_state_e;

endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr <= {STAGES{RST_VAL}};
        end else begin
          sr[0] <= d;
          for (int i = 1; i < STAGES; i++) begin
            sr[i] <= sr[i-1];
          end
        end
      end
      assign q = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sbm_beat_plan.sv
module sbm_beat_plan
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  xfer_kind_e        kind,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [2:0]        level,
  input  logic              wide,
  input  logic              beat,
  output logic [ADDR_W-1:0] b_addr,
  output logic              b_rw,
  output logic              b_uds_n,
  output logic              b_lds_n,
  output logic [15:0]       b_dout,
  output logic              two_beats,
  output logic              cap_full,
  output logic              cap_hi_lane,
  output logic              cap_to_hi
);

  localparam int HI_W = ADDR_W - 4;

  always_comb begin
    b_addr      = addr;
    b_rw        = (kind != K_WRITE);
    b_uds_n     = 1'b1;
    b_lds_n     = 1'b1;
    b_dout      = {wdata[7:0], wdata[7:0]};
    two_beats   = 1'b0;
    cap_full    = 1'b0;
    cap_hi_lane = 1'b0;
    cap_to_hi   = 1'b0;
    if (kind == K_IACK) begin
      b_addr  = {{HI_W{1'b1}}, level, 1'b1};
      b_lds_n = 1'b0;
    end else if (wide) begin
      if (word) begin
        b_addr   = {addr[ADDR_W-1:1], 1'b0};
        b_uds_n  = 1'b0;
        b_lds_n  = 1'b0;
        b_dout   = wdata;
        cap_full = 1'b1;
      end else begin
        b_uds_n     = addr[0];
        b_lds_n     = ~addr[0];
        cap_hi_lane = ~addr[0];
      end
    end else begin
      b_lds_n = 1'b0;
      if (word) begin
        two_beats = 1'b1;
        b_addr    = {addr[ADDR_W-1:1], beat};
        b_dout    = beat ? {wdata[7:0], wdata[7:0]} : {wdata[15:8], wdata[15:8]};
        cap_to_hi = ~beat;
      end
    end
  end

endmodule

// File: rtl/sbm_cycle_fsm.sv
module sbm_cycle_fsm
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              hold,
  input  logic              ack,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [2:0]        req_level,
  input  logic [15:0]       din,
  output logic [ADDR_W-1:0] addr,
  output logic              rw,
  output logic              as_n,
  output logic              uds_n,
  output logic              lds_n,
  output logic [15:0]       dout,
  output logic              dout_oe,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              idle
);

  seq_state_e        state;
  xfer_kind_e        kind_q;
  logic              word_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic [2:0]        level_q;
  logic              beat_q;
  logic [15:0]       rdata_q;

  // planner inputs: live request while idle, latched request otherwise
  logic              take;
  xfer_kind_e        p_kind;
  logic              p_word;
  logic [ADDR_W-1:0] p_in_addr;
  logic [15:0]       p_wdata;
  logic [2:0]        p_level;
  logic              p_beat;

  logic [ADDR_W-1:0] p_addr;
  logic              p_rw, p_uds_n, p_lds_n, p_two, p_full, p_hi_lane, p_to_hi;
  logic [15:0]       p_dout;
  logic [7:0]        lane_byte;

  assign take      = (state == S_IDLE);
  assign p_kind    = take ? xfer_kind_e'(req_kind) : kind_q;
  assign p_word    = take ? req_word  : word_q;
  assign p_in_addr = take ? req_addr  : addr_q;
  assign p_wdata   = take ? req_wdata : wdata_q;
  assign p_level   = take ? req_level : level_q;
  assign p_beat    = (state == S_RECOVER) ? 1'b1 : (take ? 1'b0 : beat_q);

  sbm_beat_plan #(.ADDR_W(ADDR_W)) u_plan (
    .kind        (p_kind),
    .word        (p_word),
    .addr        (p_in_addr),
    .wdata       (p_wdata),
    .level       (p_level),
    .wide        (wide),
    .beat        (p_beat),
    .b_addr      (p_addr),
    .b_rw        (p_rw),
    .b_uds_n     (p_uds_n),
    .b_lds_n     (p_lds_n),
    .b_dout      (p_dout),
    .two_beats   (p_two),
    .cap_full    (p_full),
    .cap_hi_lane (p_hi_lane),
    .cap_to_hi   (p_to_hi)
  );

  assign idle      = (state == S_IDLE);
  assign req_ready = idle && !hold;
  assign lane_byte = p_hi_lane ? din[15:8] : din[7:0];
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      kind_q    <= K_READ;
      word_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      level_q   <= '0;
      beat_q    <= 1'b0;
      rdata_q   <= '0;
      addr      <= '0;
      rw        <= 1'b1;
      as_n      <= 1'b1;
      uds_n     <= 1'b1;
      lds_n     <= 1'b1;
      dout      <= '0;
      dout_oe   <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            kind_q  <= p_kind;
            word_q  <= req_word;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            level_q <= req_level;
            beat_q  <= 1'b0;
            rdata_q <= '0;
            addr    <= p_addr;
            rw      <= p_rw;
            dout    <= p_dout;
            dout_oe <= (p_kind == K_WRITE);
            state   <= S_SETUP;
          end
        end
        S_SETUP: begin
          as_n  <= 1'b0;
          uds_n <= p_uds_n;
          lds_n <= p_lds_n;
          state <= S_STROBE;
        end
        S_STROBE: begin
          if (ack) begin
            as_n  <= 1'b1;
            uds_n <= 1'b1;
            lds_n <= 1'b1;
            if (rw) begin
              if (p_full)       rdata_q        <= din;
              else if (p_to_hi) rdata_q[15:8]  <= lane_byte;
              else              rdata_q[7:0]   <= lane_byte;
            end
            state <= S_RECOVER;
          end
        end
        S_RECOVER: begin
          if (!ack) begin
            if (p_two && !beat_q) begin
              beat_q <= 1'b1;
              addr   <= p_addr;
              dout   <= p_dout;
              state  <= S_SETUP;
            end else begin
              rsp_valid <= 1'b1;
              dout_oe   <= 1'b0;
              state     <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_setup_before_as_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |-> ($stable(addr) && $stable(rw)));

  p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
    (!as_n && $past(!as_n)) |-> $stable(addr));

  p_wdata_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (!as_n && !rw) |-> dout_oe);

  p_strobe_with_as_r4: assert property (@(posedge clk) disable iff (rst)
    (!uds_n || !lds_n) |-> !as_n);

  p_narrow_lower_only_r5: assert property (@(posedge clk) disable iff (rst)
    !wide |-> uds_n);

  p_iack_address_r6: assert property (@(posedge clk) disable iff (rst)
    (!as_n && kind_q == K_IACK) |-> ((&addr[ADDR_W-1:4]) && addr[0] && rw));

  p_wait_for_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (!as_n && !ack) |=> !as_n);

  p_ack_released_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |-> !$past(ack));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sbm_arbiter.sv
module sbm_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic br,
  input  logic idle,
  output logic granted
);

  always_ff @(posedge clk) begin
    if (rst) granted <= 1'b0;
    else     granted <= br && (granted || idle);
  end

  p_grant_between_cycles_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(granted) |-> $past(idle));

  p_release_on_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (granted && !br) |=> !granted);

endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wide,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [2:0]        req_level,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic              bus_rw,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_ctl_oe,
  output logic [15:0]       bus_dout,
  output logic              bus_dout_oe,
  input  logic [15:0]       bus_din,
  input  logic              bus_dtack_n,
  input  logic              bus_br_n,
  output logic              bus_bg_n
);

  logic mode_q;
  logic dtack_s_n, br_s_n;
  logic ack, br, granted, idle, oe_fsm;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_wide;
  end

  sbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ack (
    .clk (clk), .rst (rst), .d (bus_dtack_n), .q (dtack_s_n)
  );

  sbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_br (
    .clk (clk), .rst (rst), .d (bus_br_n), .q (br_s_n)
  );

  assign ack = !dtack_s_n;
  assign br  = !br_s_n;

  sbm_arbiter u_arb (
    .clk     (clk),
    .rst     (rst),
    .br      (br),
    .idle    (idle),
    .granted (granted)
  );

  sbm_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wide      (mode_q),
    .hold      (granted || br),
    .ack       (ack),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_word  (req_word),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_level (req_level),
    .din       (bus_din),
    .addr      (bus_addr),
    .rw        (bus_rw),
    .as_n      (bus_as_n),
    .uds_n     (bus_uds_n),
    .lds_n     (bus_lds_n),
    .dout      (bus_dout),
    .dout_oe   (oe_fsm),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .idle      (idle)
  );

  assign bus_addr_oe = !granted;
  assign bus_ctl_oe  = !granted;
  assign bus_dout_oe = oe_fsm && !granted;
  assign bus_bg_n    = !granted;

  p_granted_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_bg_n |-> (bus_as_n && bus_uds_n && bus_lds_n && !req_ready));

endmodule

// File: tb/strobe_bus_master_tb.sv
module strobe_bus_master_tb;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_wide = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic          req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [2:0]    req_level = '0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] addr;
  logic          addr_oe, rw, as_n, uds_n, lds_n, ctl_oe, dout_oe, bg_n;
  logic [15:0]   dout;
  logic [15:0]   din = 16'hA5A5;
  logic          dtack_n = 1'b1;
  logic          br_n = 1'b1;

  always #5 clk = ~clk;

  strobe_bus_master #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
    .clk (clk), .rst (rst), .mode_wide (mode_wide),
    .req_valid (req_valid), .req_ready (req_ready), .req_kind (req_kind),
    .req_word (req_word), .req_addr (req_addr), .req_wdata (req_wdata),
    .req_level (req_level), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .bus_addr (addr), .bus_addr_oe (addr_oe), .bus_rw (rw), .bus_as_n (as_n),
    .bus_uds_n (uds_n), .bus_lds_n (lds_n), .bus_ctl_oe (ctl_oe),
    .bus_dout (dout), .bus_dout_oe (dout_oe), .bus_din (din),
    .bus_dtack_n (dtack_n), .bus_br_n (br_n), .bus_bg_n (bg_n)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  logic       cur_mode = 1'b1;
  logic       cur_iack = 1'b0;
  logic [2:0] cur_lvl  = '0;
  int         cur_wait = 0;
  int         cur_tail = 0;
  logic [7:0] lg_addr [4];
  logic       lg_uds [4];
  logic       lg_lds [4];
  logic       lg_rw  [4];
  int         lg_n = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // bus-side responder and protocol monitor
  initial begin
    logic       prev_as, prev_rw, prev_strb, strb;
    logic [7:0] prev_addr, a;
    int         wcnt, tcnt;
    prev_as = 1'b1; prev_rw = 1'b1; prev_strb = 1'b0; prev_addr = '0;
    wcnt = 0; tcnt = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        strb = !uds_n || !lds_n;
        if (prev_as && !as_n) begin
          chk(addr == prev_addr && rw == prev_rw && addr_oe && ctl_oe && (rw || dout_oe),
              "R2", "setup before strobe", {addr, 7'd0, rw, dout_oe}, {prev_addr, 7'd0, prev_rw, 1'b1});
          chk(dtack_n, "R8", "strobe while ack low", dtack_n, 1);
        end
        if (prev_strb && !strb)
          chk(!dtack_n, "R7", "strobes negated without ack", dtack_n, 0);
        if (!bg_n)
          chk(as_n && uds_n && lds_n && !addr_oe && !ctl_oe && !dout_oe, "R10", "granted bus quiet",
              {as_n, uds_n, lds_n, addr_oe, ctl_oe, dout_oe}, 6'b111000);
        if (strb && dtack_n) begin
          if (wcnt >= cur_wait) begin
            a = addr;
            if (lg_n < 4) begin
              lg_addr[lg_n] = a; lg_uds[lg_n] = uds_n; lg_lds[lg_n] = lds_n; lg_rw[lg_n] = rw;
              lg_n++;
            end
            if (cur_iack)      din = {8'hEE, 8'h40 | {5'd0, cur_lvl}};
            else if (cur_mode) din = {mem[{a[7:1], 1'b0}], mem[{a[7:1], 1'b1}]};
            else               din = {mem[a], mem[a]};
            if (!rw && dout_oe) begin
              if (cur_mode) begin
                if (!uds_n) mem[{a[7:1], 1'b0}] = dout[15:8];
                if (!lds_n) mem[{a[7:1], 1'b1}] = dout[7:0];
              end else begin
                mem[a] = dout[7:0];
              end
            end
            dtack_n = 1'b0;
            wcnt = 0;
          end else begin
            wcnt++;
          end
        end
        if (!strb) wcnt = 0;
        if (!strb && !dtack_n) begin
          if (tcnt >= cur_tail) begin
            dtack_n = 1'b1; din = 16'hA5A5; tcnt = 0;
          end else begin
            tcnt++;
          end
        end
        prev_as = as_n; prev_rw = rw; prev_addr = addr; prev_strb = strb;
      end
    end
  end

  task automatic do_req(input logic [1:0] k, input logic w, input logic [7:0] a,
                        input logic [15:0] wd, input logic [2:0] lv);
    logic [15:0] got, exp_rd;
    logic [7:0]  ea [2];
    logic        eu [2];
    logic        el [2];
    logic        erw;
    int          en;
    string       tag;
    cur_iack = (k == 2'd2);
    cur_lvl  = lv;
    lg_n     = 0;
    erw = (k != 2'd1);
    tag = cur_iack ? "R6" : (cur_mode ? "R4" : "R5");
    en = 1; ea[1] = '0; eu[1] = 1'b1; el[1] = 1'b1;
    if (cur_iack) begin
      ea[0] = {4'hF, lv, 1'b1}; eu[0] = 1'b1; el[0] = 1'b0;
      exp_rd = {8'h00, 8'h40 | {5'd0, lv}};
    end else begin
      exp_rd = w ? {ref_mem[{a[7:1], 1'b0}], ref_mem[{a[7:1], 1'b1}]} : {8'h00, ref_mem[a]};
      if (cur_mode) begin
        if (w) begin ea[0] = {a[7:1], 1'b0}; eu[0] = 1'b0; el[0] = 1'b0; end
        else   begin ea[0] = a; eu[0] = a[0]; el[0] = ~a[0]; end
      end else begin
        eu[0] = 1'b1; el[0] = 1'b0;
        if (w) begin
          en = 2; ea[0] = {a[7:1], 1'b0}; ea[1] = {a[7:1], 1'b1}; eu[1] = 1'b1; el[1] = 1'b0;
        end else begin
          ea[0] = a;
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_word = w; req_addr = a; req_wdata = wd; req_level = lv;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R11", "response longer than one clock", rsp_valid, 0);
    chk(lg_n == en, tag, "cycle count", lg_n, en);
    for (int i = 0; i < en; i++) begin
      if (i < lg_n) begin
        chk(lg_addr[i] == ea[i] && lg_uds[i] == eu[i] && lg_lds[i] == el[i], tag, "address/lanes",
            {lg_addr[i], 2'b0, lg_uds[i], lg_lds[i]}, {ea[i], 2'b0, eu[i], el[i]});
        chk(lg_rw[i] == erw, "R3", "direction", lg_rw[i], erw);
      end
    end
    if (k != 2'd1) begin
      chk(got == exp_rd, "R7", "read data", got, exp_rd);
    end else if (w) begin
      ref_mem[{a[7:1], 1'b0}] = wd[15:8];
      ref_mem[{a[7:1], 1'b1}] = wd[7:0];
    end else begin
      ref_mem[a] = wd[7:0];
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mode_wide = m; cur_mode = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 37 + 11) & 255);
      ref_mem[i] = mem[i];
    end
    chk(as_n && uds_n && lds_n && bg_n && !dout_oe && !rsp_valid && addr_oe && ctl_oe && req_ready,
        "R1", "state after reset",
        {as_n, uds_n, lds_n, bg_n, dout_oe, rsp_valid, addr_oe, ctl_oe, req_ready}, 9'b111100111);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int m = 1; m >= 0; m--) begin
      do_reset(m[0]);
      for (int ai = 0; ai < 256; ai++) begin
        logic [7:0] av;
        av = ai[7:0];
        cur_wait = ai % 4;
        cur_tail = ai % 3;
        do_req(2'd1, 1'b1, av, {av ^ 8'h3C, av + 8'h11}, 3'd0);
        do_req(2'd0, 1'b0, av, 16'h0, 3'd0);
        do_req(2'd0, 1'b1, av, 16'h0, 3'd0);
        do_req(2'd1, 1'b0, av, {8'h00, ~av}, 3'd0);
        do_req(2'd0, 1'b0, av, 16'h0, 3'd0);
      end
      for (int lv = 0; lv < 8; lv++) begin
        cur_wait = lv % 4;
        do_req(2'd2, 1'b0, 8'h00, 16'h0, lv[2:0]);
      end
    end

    // R9: width input changed after reset has no effect
    do_reset(1'b1);
    cur_wait = 1; cur_tail = 0;
    mode_wide = 1'b0;
    do_req(2'd0, 1'b1, 8'h20, 16'h0, 3'd0);
    chk(lg_n == 1 && !lg_uds[0] && !lg_lds[0], "R9", "width follows reset capture",
        {lg_n[7:0], lg_uds[0], lg_lds[0]}, {8'd1, 2'b00});
    mode_wide = 1'b1;

    // R10: request during a cycle is deferred, held requests wait for release
    cur_wait = 12;
    fork
      do_req(2'd0, 1'b1, 8'h40, 16'h0, 3'd0);
      begin
        while (uds_n && lds_n) @(negedge clk);
        br_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(bg_n && !as_n, "R10", "grant deferred during cycle", {bg_n, as_n}, 2'b10);
      end
    join
    repeat (6) @(negedge clk);
    chk(!bg_n && !addr_oe && !ctl_oe && !dout_oe, "R10", "grant after cycle",
        {bg_n, addr_oe, ctl_oe, dout_oe}, 4'b0000);
    cur_wait = 0;
    fork
      do_req(2'd1, 1'b1, 8'h42, 16'hBEEF, 3'd0);
      begin
        repeat (8) @(negedge clk);
        chk(!req_ready && lg_n == 0 && !bg_n, "R10", "request held while granted",
            {req_ready, lg_n[7:0], bg_n}, 10'd0);
        br_n = 1'b1;
      end
    join
    chk(bg_n, "R10", "grant released", bg_n, 1);
    do_req(2'd0, 1'b1, 8'h42, 16'h0, 3'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule